// File: doc/BRIEF.md
# Three-Input Bitwise Lookup Logic Unit

This execution unit evaluates an arbitrary three-input, one-output Boolean function independently on every bit of a 64-bit word. The function is chosen by an 8-bit truth table that arrives with the operation as an immediate. The three inputs to the function are the old contents of the destination register and two source operands. Because the destination takes part as an input, the operation is read-modify-write: the caller supplies the old destination value and writes the result back into the same register.

Operations enter on a valid/ready input channel and leave on a valid/ready output channel through a single result register. An accepted operation appears at the output on the next clock edge. The output holds its result until the consumer takes it. While the output is full and not being drained, `in_ready` is low and the producer must hold its operation. When the output is drained in the same cycle that a new operation is offered, both transfers happen together, so back-to-back operations run at one per cycle. When the record flag of an operation is set, the unit also returns a 4-bit condition summary of the result, with a write strobe for the condition register.

Top module: `bitlut3_unit`

## Requirements
- R1: After reset, `out_valid`, `out_rd_wen` and `out_cr_wen` are 0 and `in_ready` is 1.
- R2: For each bit i, result bit i equals bit j of `in_table`, where bit j has weight 2^j and j = 4*dest[i] + 2*srcA[i] + srcB[i].
- R3: Table entry 0 (weight 1) applies where all three input bits are 0 and entry 7 (weight 128) where all three are 1. Table 0x00 gives all zeros, 0xFF gives all ones, 0x01 gives ~dest&~A&~B, and 0x80 gives dest&A&B.
- R4: The old destination is the most significant selector. Table 0xF0 returns the old destination, 0xCC returns source A and 0xAA returns source B.
- R5: Table 0xD8 is a bitwise multiplex: a result bit is the A bit where the B bit is 1 and the old destination bit where the B bit is 0.
- R6: With the record flag set, `out_cr_wen` pulses together with the result transfer and `out_cr` = {LT, GT, EQ, SO} in bits [3:0]. LT, GT and EQ come from a signed comparison of the result with zero, and SO copies `in_so` as sampled at acceptance.
- R7: With the record flag clear, `out_cr_wen` stays 0 and `out_cr` is 0.
- R8: The result is registered. `out_valid` rises the cycle after an operation is accepted, and `out_result` and `out_cr` stay stable while `out_valid` is high and `out_ready` is low.
- R9: `in_ready` is low exactly while `out_valid` is high and `out_ready` is low. An operation offered during a stall is taken on the cycle the output drains, with no lost cycle.
- R10: `out_rd_wen` is high exactly in cycles where `out_valid` and `out_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take the operation |
| in_dest | input | 64 | Old destination value (most significant selector) |
| in_src_a | input | 64 | Source A (middle selector) |
| in_src_b | input | 64 | Source B (least significant selector) |
| in_table | input | 8 | Truth table, bit j chosen by index j |
| in_record | input | 1 | Request condition summary |
| in_so | input | 1 | Summary-overflow value copied into the summary |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Value to write back to the destination |
| out_rd_wen | output | 1 | Destination write strobe (transfer) |
| out_cr_wen | output | 1 | Condition field write strobe |
| out_cr | output | 4 | Condition summary {LT, GT, EQ, SO} |

## Verification
The bench builds the unit with its default 64-bit width and 3-bit selector. With these values the sign comparison acts on bit 63, so both negative and positive full-width results can be produced. All eight table entries are driven in one word by operand patterns that place every selector combination in separate bit lanes. The single result register lets a stall of a few cycles, and a drain that coincides with a new offer, be exercised directly from the ports.

// File: rtl/bitlut3_pkg.sv
package bitlut3_pkg;

  // Selector count for the lookup: old destination, source A, source B.
  localparam int SEL_W = 3;
  localparam int TBL_W = 1 << SEL_W;
  localparam int CR_W  = 4;

  // Condition summary, most significant field first.
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

endpackage

// File: rtl/bitlut3_lanes.sv
module bitlut3_lanes
  import bitlut3_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] dest,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [TBL_W-1:0]  table_bits,
  output logic [DATA_W-1:0] result
);

  // One independent 8:1 lookup per bit lane.
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    logic [SEL_W-1:0] sel;
    assign sel       = {dest[i], src_a[i], src_b[i]};
    assign result[i] = table_bits[sel];
  end

endmodule

// File: rtl/bitlut3_cond.sv
module bitlut3_cond
  import bitlut3_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] value,
  input  logic              so_in,
  input  logic              enable,
  output cond_t             summary
);

  logic neg, zero;

  assign neg  = value[DATA_W-1];
  assign zero = (value == '0);

  always_comb begin
    summary = '0;
    if (enable) begin
      summary.lt = neg;
      summary.gt = !neg && !zero;
      summary.eq = zero;
      summary.so = so_in;
    end
  end

endmodule

// File: rtl/bitlut3_stage.sv
module bitlut3_stage
  import bitlut3_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_result,
  input  cond_t             in_cond,
  input  logic              in_rec,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output cond_t             out_cond,
  output logic              out_rec
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_cond   <= '0;
      out_rec    <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_result <= in_result;
        out_cond   <= in_cond;
        out_rec    <= in_rec;
      end
    end
  end

endmodule

// File: rtl/bitlut3_unit.sv
module bitlut3_unit
  import bitlut3_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_dest,
  input  logic [DATA_W-1:0]   in_src_a,
  input  logic [DATA_W-1:0]   in_src_b,
  input  logic [TBL_W-1:0]    in_table,
  input  logic                in_record,
  input  logic                in_so,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_result,
  output logic                out_rd_wen,
  output logic                out_cr_wen,
  output logic [CR_W-1:0]     out_cr
);

  logic [DATA_W-1:0] lut_res;
  cond_t             lut_cond;
  cond_t             held_cond;
  logic              held_rec;

  bitlut3_lanes #(.DATA_W(DATA_W)) u_lanes (
    .dest       (in_dest),
    .src_a      (in_src_a),
    .src_b      (in_src_b),
    .table_bits (in_table),
    .result     (lut_res)
  );

  bitlut3_cond #(.DATA_W(DATA_W)) u_cond (
    .value   (lut_res),
    .so_in   (in_so),
    .enable  (in_record),
    .summary (lut_cond)
  );

  bitlut3_stage #(.DATA_W(DATA_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_result  (lut_res),
    .in_cond    (lut_cond),
    .in_rec     (in_record),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result),
    .out_cond   (held_cond),
    .out_rec    (held_rec)
  );

  assign out_rd_wen = out_valid && out_ready;
  assign out_cr_wen = out_rd_wen && held_rec;
  assign out_cr     = held_cond;

endmodule

// File: rtl/bitlut3_chk.sv
module bitlut3_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_dest,
  input logic [7:0]        in_table,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_rd_wen,
  input logic              out_cr_wen,
  input logic [3:0]        out_cr
);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_rd_wen && !out_cr_wen));

  p_dest_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_table == 8'hF0) |=> (out_result == $past(in_dest)));

  p_one_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_cr_wen |-> ($countones(out_cr[3:1]) == 1));

  p_eq_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cr_wen && out_cr[1]) |-> (out_result == '0));

  p_cr_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_cr_wen |-> out_rd_wen);

  p_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_cr)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_wen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> out_rd_wen);

endmodule

bind bitlut3_unit bitlut3_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_dest    (in_dest),
  .in_table   (in_table),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_rd_wen (out_rd_wen),
  .out_cr_wen (out_cr_wen),
  .out_cr     (out_cr)
);

// File: tb/bitlut3_unit_bench.sv
`timescale 1ns/1ps
module bitlut3_unit_bench;

  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_dest = '0, in_src_a = '0, in_src_b = '0;
  logic [7:0]   in_table = '0;
  logic         in_record = 1'b0, in_so = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_result;
  logic         out_rd_wen, out_cr_wen;
  logic [3:0]   out_cr;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  bitlut3_unit #(.DATA_W(W)) u_bitlut3_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_dest(in_dest), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_table(in_table), .in_record(in_record), .in_so(in_so),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_rd_wen(out_rd_wen),
    .out_cr_wen(out_cr_wen), .out_cr(out_cr)
  );

  // Selector lanes: each bit position of d/a/b covers one of the 8 indices.
  localparam logic [W-1:0] PD = 64'hF0F0_F0F0_F0F0_F0F0;
  localparam logic [W-1:0] PA = 64'hCCCC_CCCC_CCCC_CCCC;
  localparam logic [W-1:0] PB = 64'hAAAA_AAAA_AAAA_AAAA;

  function automatic logic [W-1:0] ref_lut(logic [W-1:0] d, logic [W-1:0] a,
                                           logic [W-1:0] b, logic [7:0] t);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = t[4*d[i] + 2*a[i] + b[i]];
    return r;
  endfunction

  function automatic logic [3:0] ref_cr(logic [W-1:0] r, logic so);
    return {$signed(r) < 0, $signed(r) > 0, r == '0, so};
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One operation through an empty unit; returns what the output showed.
  task automatic run_op(logic [W-1:0] d, logic [W-1:0] a, logic [W-1:0] b,
                        logic [7:0] t, logic rec, logic so,
                        output logic [W-1:0] res, output logic [3:0] cr,
                        output logic crw);
    @(negedge clk);
    in_dest = d; in_src_a = a; in_src_b = b; in_table = t;
    in_record = rec; in_so = so; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 out_valid after accept", W'(out_valid), W'(1));
    out_ready = 1'b1;
    #1;
    check("R10 rd_wen on transfer", W'(out_rd_wen), W'(1));
    res = out_result; cr = out_cr; crw = out_cr_wen;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check("R8 out_valid cleared after drain", W'(out_valid), W'(0));
  endtask

  task automatic t_reset();
    check("R1 out_valid", W'(out_valid), W'(0));
    check("R1 out_rd_wen", W'(out_rd_wen), W'(0));
    check("R1 out_cr_wen", W'(out_cr_wen), W'(0));
    check("R1 in_ready", W'(in_ready), W'(1));
  endtask

  task automatic t_lookup();
    logic [W-1:0] r; logic [3:0] c; logic w;
    logic [7:0] tbls [4] = '{8'h96, 8'h3C, 8'h5A, 8'hE8};
    for (int k = 0; k < 4; k++) begin
      run_op(PD, PA, PB, tbls[k], 1'b0, 1'b0, r, c, w);
      check("R2 lane lookup", r, ref_lut(PD, PA, PB, tbls[k]));
    end
    run_op(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0F1E_2D3C_4B5A_6978,
           8'h6B, 1'b0, 1'b0, r, c, w);
    check("R2 mixed operands", r, ref_lut(64'h0123_4567_89AB_CDEF,
          64'hFEDC_BA98_7654_3210, 64'h0F1E_2D3C_4B5A_6978, 8'h6B));
  endtask

  task automatic t_corners();
    logic [W-1:0] r; logic [3:0] c; logic w;
    run_op(PD, PA, PB, 8'h00, 1'b0, 1'b0, r, c, w);
    check("R3 table 0x00", r, '0);
    run_op(PD, PA, PB, 8'hFF, 1'b0, 1'b0, r, c, w);
    check("R3 table 0xFF", r, '1);
    run_op(PD, PA, PB, 8'h01, 1'b0, 1'b0, r, c, w);
    check("R3 entry 0 all-zero", r, ~PD & ~PA & ~PB);
    run_op(PD, PA, PB, 8'h80, 1'b0, 1'b0, r, c, w);
    check("R3 entry 7 all-one", r, PD & PA & PB);
  endtask

  task automatic t_selectors();
    logic [W-1:0] r; logic [3:0] c; logic w;
    logic [W-1:0] d = 64'hDEAD_BEEF_0BAD_F00D;
    logic [W-1:0] a = 64'h1357_9BDF_2468_ACE0;
    logic [W-1:0] b = 64'h8000_0000_FFFF_0001;
    run_op(d, a, b, 8'hF0, 1'b0, 1'b0, r, c, w);
    check("R4 0xF0 returns dest", r, d);
    run_op(d, a, b, 8'hCC, 1'b0, 1'b0, r, c, w);
    check("R4 0xCC returns A", r, a);
    run_op(d, a, b, 8'hAA, 1'b0, 1'b0, r, c, w);
    check("R4 0xAA returns B", r, b);
  endtask

  task automatic t_mux();
    logic [W-1:0] r; logic [3:0] c; logic w;
    logic [W-1:0] d = 64'h5555_0000_FFFF_1234;
    logic [W-1:0] a = 64'hAAAA_FFFF_0000_4321;
    logic [W-1:0] b = 64'hFF00_FF00_F0F0_0FF0;
    run_op(d, a, b, 8'hD8, 1'b0, 1'b0, r, c, w);
    check("R5 multiplex", r, (d & ~b) | (a & b));
  endtask

  task automatic t_record();
    logic [W-1:0] r; logic [3:0] c; logic w;
    run_op(64'h8000_0000_0000_0000, '0, '0, 8'hF0, 1'b1, 1'b0, r, c, w);
    check("R6 cr_wen negative", W'(w), W'(1));
    check("R6 cr negative", W'(c), W'(4'b1000));
    run_op(64'h0000_0000_0000_0005, '0, '0, 8'hF0, 1'b1, 1'b1, r, c, w);
    check("R6 cr positive with SO", W'(c), W'(4'b0101));
    run_op(PD, PA, PB, 8'h00, 1'b1, 1'b1, r, c, w);
    check("R6 cr zero with SO", W'(c), W'(ref_cr('0, 1'b1)));
    run_op(PD, PA, PB, 8'hFF, 1'b0, 1'b1, r, c, w);
    check("R7 cr_wen clear", W'(w), W'(0));
    check("R7 cr zero", W'(c), W'(0));
  endtask

  task automatic t_backpressure();
    logic [W-1:0] e1, e2;
    e1 = ref_lut(PD, PA, PB, 8'h17);
    e2 = ref_lut(PD, PA, PB, 8'hE1);
    @(negedge clk);
    in_dest = PD; in_src_a = PA; in_src_b = PB; in_table = 8'h17;
    in_record = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_table = 8'hE1;               // second op offered during the stall
    for (int k = 0; k < 3; k++) begin
      check("R9 in_ready low during stall", W'(in_ready), W'(0));
      check("R8 result held", out_result, e1);
      check("R10 no rd_wen while stalled", W'(out_rd_wen), W'(0));
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1;
    check("R9 in_ready when draining", W'(in_ready), W'(1));
    check("R8 first result at drain", out_result, e1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second op taken on drain cycle", W'(out_valid), W'(1));
    check("R9 second result", out_result, e2);
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check("R10 empty after drain", W'(out_rd_wen), W'(0));
  endtask

  task automatic t_stream();
    logic [7:0] tbls [4] = '{8'h0F, 8'h66, 8'hB4, 8'h2D};
    @(negedge clk);
    out_ready = 1'b1;
    in_dest = PD; in_src_a = PA; in_src_b = PB; in_record = 1'b0;
    for (int k = 0; k < 4; k++) begin
      in_table = tbls[k]; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R9 streaming result", out_result, ref_lut(PD, PA, PB, tbls[k]));
      check("R10 streaming rd_wen", W'(out_rd_wen), W'(1));
    end
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check("R8 idle after stream", W'(out_valid), W'(0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog actual=hung expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_lookup();
    t_corners();
    t_selectors();
    t_mux();
    t_record();
    t_backpressure();
    t_stream();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule